// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is a two-wire serial bus slave in front of a small byte-wide storage array. It oversamples the clock and data lines with the system clock and finds start and stop conditions. It then decodes a device byte and answers three read flows. A current read returns the byte at an internal pointer. A sequential read keeps returning bytes for as long as the master acknowledges each one. A random read first loads the pointer through a write-mode device byte and a word-address byte, and then switches to reading after a repeated start.

The write direction goes only as far as loading the pointer. Data bytes that follow the word address are neither acknowledged nor stored. The array is filled through a separate preload port. The slave never drives the data line high. It only asks for it to be pulled low, through an open-drain enable.

Top module: `twi_eeprom_reader`

## Requirements
- R1: After synchronous reset the data-line pull-down is released and the byte pointer is 0, so the first current read returns array byte 0.
- R2: A start (data falls while clock is high) restarts device-byte decoding from its first bit, even in the middle of a byte. A stop (data rises while clock is high) returns the slave to idle and leaves the pointer unchanged.
- R3: Device byte, MSB first: bits 7..2 must equal bits 7..2 of `DEV_BYTE_ID` (default 0xA0). Bit 1 is a block select. Bit 0 is 1 for read and 0 for write. On a match the slave pulls data low during the 9th clock. The block select bit of a read-mode byte has no effect.
- R4: A device byte whose upper six bits do not match gets no acknowledge. Every later byte is ignored until the next start, and the pointer is unchanged.
- R5: After a read-mode acknowledge the slave sends the byte at the pointer, MSB first. Data changes only after clock falling edges and holds steady while the clock is high. The pointer increments after every byte sent.
- R6: If the master acknowledges a data byte, the next byte follows from the incremented pointer. If it does not, the slave releases the line and goes idle.
- R7: Incrementing the pointer past address 511 wraps it to 0.
- R8: A write-mode device byte followed by a word-address byte (both acknowledged) loads the pointer with {block select, word address}. A repeated start with a read-mode device byte then returns that location.
- R9: A byte sent after the word address in write mode is not acknowledged and changes neither the array nor the pointer.
- R10: The pull-down is active only during an acknowledge clock or while a 0 data bit is being sent.
- R11: The preload port writes `ld_data` to array address `ld_addr` on each clock where `ld_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved bus) |
| sda_pull_o | output | 1 | 1 = pull data line low |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | ADDR_W (9) | Preload address |
| ld_data | input | 8 | Preload byte |

## Verification
The bench aims at pointer handling where a wrong design gives the wrong byte. It runs a sequential read across address 511, which a design without the wrap would answer with stale or out-of-range data. It sends a data byte after the word address, which a design that treats it as a write would acknowledge or use to move the pointer. It also sends a foreign device byte followed by a matching byte without a new start, which a design that keeps decoding would wrongly acknowledge. A start inside a half-sent byte and a read-mode byte carrying a set block select bit expose a slave that loses bit alignment or lets the block bit override the pointer. Sampling each data bit twice during the high phase catches data that changes on the wrong edge.

// File: rtl/twi_rd_pkg.sv
package twi_rd_pkg;

    localparam int unsigned TWI_ADDR_W = 9;
    localparam int unsigned TWI_SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK,
        ST_WADDR,
        ST_TX,
        ST_MACK
    } twi_state_t;

    typedef enum logic [1:0] {
        AK_READ,
        AK_WRITE,
        AK_WORD
    } ack_kind_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    // Open-drain decision: pull low while acknowledging or sending a zero.
    function automatic logic pull_low(input twi_state_t st, input logic tx_msb);
        return (st == ST_ACK) || (st == ST_TX && !tx_msb);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_rd_pkg::*;
#(
    parameter int unsigned STAGES = TWI_SYNC_STAGES
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d;
    logic scl_s, sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end

    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && ptr == TOP) |=> (ptr == '0));
endmodule

// File: rtl/twi_mem.sv
module twi_mem #(
    parameter int unsigned AW = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/twi_eeprom_reader.sv
module twi_eeprom_reader
    import twi_rd_pkg::*;
#(
    parameter int unsigned ADDR_W      = TWI_ADDR_W,
    parameter logic [7:0]  DEV_BYTE_ID = 8'hA0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data
);
    localparam int unsigned BLK_W = ADDR_W - 8;   // block-select bits in device byte
    localparam int unsigned ID_W  = 7 - BLK_W;    // identity bits in device byte

    bus_ev_t            ev;
    twi_state_t         state;
    ack_kind_t          ack_kind;
    logic [7:0]         shreg, tx;
    logic [3:0]         bit_cnt;
    logic [BLK_W-1:0]   blk_q;
    logic               mack_q;
    logic               id_ok, quiet;
    logic               ptr_load, ptr_inc;
    logic [ADDR_W-1:0]  ptr;
    logic [7:0]         rd_data;

    twi_line_sync #(.STAGES(TWI_SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i), .ev(ev)
    );

    twi_addr_ctr #(.W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .load(ptr_load), .load_val({blk_q, shreg}),
        .inc(ptr_inc), .ptr(ptr)
    );

    twi_mem #(.AW(ADDR_W)) u_mem (
        .clk(clk), .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(ld_data),
        .rd_addr(ptr), .rd_data(rd_data)
    );

    assign id_ok    = (shreg[7 -: ID_W] == DEV_BYTE_ID[7 -: ID_W]);
    assign quiet    = !ev.start && !ev.stop;
    assign ptr_load = quiet && state == ST_WADDR && ev.scl_fall && bit_cnt == 4'd8;
    assign ptr_inc  = quiet && state == ST_TX && ev.scl_fall && bit_cnt == 4'd7;
    assign sda_pull_o = pull_low(state, tx[7]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ack_kind <= AK_READ;
            shreg    <= '0;
            tx       <= '1;
            bit_cnt  <= '0;
            blk_q    <= '0;
            mack_q   <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_DEV, ST_WADDR: begin
                    if (ev.scl_rise) begin
                        shreg   <= {shreg[6:0], ev.sda};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        if (state == ST_WADDR) begin
                            state    <= ST_ACK;
                            ack_kind <= AK_WORD;
                        end else if (id_ok) begin
                            state    <= ST_ACK;
                            ack_kind <= shreg[0] ? AK_READ : AK_WRITE;
                            if (!shreg[0]) blk_q <= shreg[BLK_W:1];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        unique case (ack_kind)
                            AK_READ: begin
                                tx    <= rd_data;
                                state <= ST_TX;
                            end
                            AK_WRITE: state <= ST_WADDR;
                            default:  state <= ST_IDLE;
                        endcase
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            state <= ST_MACK;
                            tx    <= '1;
                        end else begin
                            tx      <= {tx[6:0], 1'b1};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) mack_q <= ~ev.sda;
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (mack_q) begin
                            tx    <= rd_data;
                            state <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r2_start_restarts: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_DEV && bit_cnt == 4'd0));

    a_r2_stop_idles: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> (state == ST_IDLE));

    a_r4_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && ev.scl_fall && bit_cnt == 4'd8 && !id_ok && quiet)
        |=> (state == ST_IDLE && !sda_pull_o));

    a_r5_pull_moves_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> $past(ev.scl_fall || ev.start || ev.stop));

    a_r6_nack_releases: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MACK && ev.scl_fall && !mack_q && quiet)
        |=> (state == ST_IDLE && !sda_pull_o));

    a_r10_quiet_states: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_DEV || state == ST_WADDR || state == ST_MACK)
        |-> !sda_pull_o);
endmodule

// File: tb/twi_eeprom_reader_test.sv
`timescale 1ns/1ps
module twi_eeprom_reader_test;
    localparam int AW = 9;
    localparam time Q = 100ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic pull;
    logic ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic sda_bus;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~pull;

    always #5ns clk = ~clk;

    twi_eeprom_reader uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(pull), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q;
        acked = !sda_bus;
        #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic steady);
        logic s1, s2;
        steady = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; scl_m = 1'b1; #Q; s1 = sda_bus; #Q; s2 = sda_bus;
            scl_m = 1'b0; #Q;
            b[i] = s1;
            if (s1 != s2) steady = 1'b0;
        end
        sda_m = !give_ack; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
        sda_m = 1'b1;
    endtask

    // Loads the pointer through a write-mode device byte and word address.
    task automatic set_ptr(input int a, input string req);
        logic ak;
        bus_start();
        send_byte({6'b101000, 1'(a >> 8), 1'b0}, ak);
        chk(req, ak, 1);
        send_byte(8'(a), ak);
        chk(req, ak, 1);
    endtask

    task automatic t_reset_and_current();
        logic ak, st;
        logic [7:0] d;
        chk("R1 pull released after reset", pull, 0);
        bus_start();
        send_byte(8'hA1, ak);
        chk("R3 read device byte acked", ak, 1);
        recv_byte(1'b0, d, st);
        chk("R1/R11 first read from address 0", d, pat(0));
        chk("R5 data steady while clock high", st, 1);
        bus_stop();
        chk("R10 released after stop", pull, 0);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, d, st);
        chk("R5 pointer advanced to 1", d, pat(1));
        bus_stop();
    endtask

    task automatic t_foreign();
        logic ak, st;
        logic [7:0] d;
        bus_start();
        send_byte(8'hB1, ak);
        chk("R4 foreign id not acked", ak, 0);
        send_byte(8'hA1, ak);
        chk("R4 later byte ignored until start", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, d, st);
        chk("R4 pointer unchanged", d, pat(2));
        bus_stop();
    endtask

    task automatic t_random();
        logic ak, st;
        logic [7:0] d;
        set_ptr(12'h12C, "R8 dummy write acked");
        bus_start();
        send_byte(8'hA1, ak);
        chk("R8 read after repeated start acked", ak, 1);
        recv_byte(1'b0, d, st);
        chk("R8 random read data", d, pat(12'h12C));
        bus_stop();
    endtask

    task automatic t_sequential();
        logic ak, st;
        logic [7:0] d;
        set_ptr(12'h0F0, "R8 load for sequential");
        bus_start();
        send_byte(8'hA1, ak);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k != 3, d, st);
            chk($sformatf("R6 sequential byte %0d", k), d, pat(12'h0F0 + k));
            chk("R5 sequential data steady", st, 1);
        end
        chk("R6 released after master nack", pull, 0);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic ak, st;
        logic [7:0] d;
        set_ptr(12'h1FE, "R8 load near top");
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b1, d, st);
        chk("R7 byte at 0x1FE", d, pat(12'h1FE));
        recv_byte(1'b1, d, st);
        chk("R7 byte at 0x1FF", d, pat(12'h1FF));
        recv_byte(1'b0, d, st);
        chk("R7 wrapped to 0", d, pat(0));
        bus_stop();
    endtask

    task automatic t_write_ignored();
        logic ak, st;
        logic [7:0] d;
        set_ptr(12'h055, "R8 load 0x055");
        send_byte(8'hAA, ak);
        chk("R9 data byte after word address not acked", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, d, st);
        chk("R9 pointer and array untouched", d, pat(12'h055));
        bus_stop();
    endtask

    task automatic t_abort_and_stop();
        logic ak, st;
        logic [7:0] d;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'hA3, ak);
        chk("R2 start mid-byte realigns", ak, 1);
        recv_byte(1'b0, d, st);
        chk("R3 block bit ignored on read", d, pat(12'h056));
        bus_stop();
        bus_start();
        send_byte(8'hA0, ak);
        bus_stop();
        chk("R2 stop releases line", pull, 0);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, d, st);
        chk("R2 stop keeps pointer", d, pat(12'h057));
        bus_stop();
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            ld_en = 1'b1;
            ld_addr = AW'(a);
            ld_data = pat(a);
        end
        @(negedge clk);
        ld_en = 1'b0;
        #Q;
        t_reset_and_current();
        t_foreign();
        t_random();
        t_sequential();
        t_wrap();
        t_write_ignored();
        t_abort_and_stop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule